// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Strap Configuration Latch

This block gathers reset requests from seven sources and turns them into three reset outputs: one for the external reset pad, one for the clock module, and one for all other internal logic. The power-up input is the block's own synchronous reset, and it also counts as a source. A request from the external pin or from clock-reference loss takes effect on the next clock edge, whatever the bus is doing. A request from the watchdog, from an internal halt, from a test request or from the bus monitor is held back until the current bus cycle has ended. This lets a write that is already under way complete.

A small bus monitor watches each bus cycle. If a cycle goes unacknowledged for too long, the monitor ends it with a one-clock bus-error pulse, and that pulse is itself a reset source. Software can switch the monitor off, but it is forced back on while a deferred request waits, so a hung cycle cannot block a reset.

Once asserted, reset is held for a fixed number of clocks. On the last of those clocks, the strap inputs (the data bus and three option pins) are latched and decoded into a module field, a pin field, the external bus mode, a clock-source select and a background-debug enable. A one-hot cause register records the source of the most recent reset.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_i` is high, all three reset outputs are high and `cause_o` reads 7'h01. The configuration outputs show the all-high strap defaults: module 4'hF, pins 11'h7FF, `bus_mode_o`=2, `clk_sel_o`=1, `bgnd_en_o`=0.
- R2: A high on `pin_rst_req_i` or `clk_loss_req_i` while reset is inactive asserts the reset outputs at the next clock edge, even during an unacknowledged bus cycle.
- R3: A high on `wdog_req_i`, `halt_req_i` or `test_req_i` is remembered. Reset asserts only at the first clock edge at which the bus is at a boundary. A boundary is any cycle in which `bus_cyc_i` is low, `bus_ack_i` is high, or `bus_err_o` is high.
- R4: Reset stays asserted for exactly HOLD_CYCLES clocks after the edge that asserted it (or after the last edge with `rst_i` high). All three outputs then release on the same edge.
- R5: `ext_rst_o` and `mst_rst_o` assert for every source. `clk_rst_o` asserts for every source except the watchdog.
- R6: `cause_o` is one-hot, with bit 0 power-up, 1 pin, 2 clock loss, 3 watchdog, 4 halt, 5 test and 6 bus monitor. When several sources qualify at the same edge, the lowest bit wins.
- R7: The configuration outputs take the strap inputs present during the last clock of reset. They hold that value until the next reset, whatever the inputs do afterwards.
- R8: The configuration fields decode as follows. Module = data[15:12] and pins = {data[11:2], data[0]}. `bus_mode_o` is 0 (single-chip) when `berr_n_i` is low, 1 (24-bit address, 8-bit data) when `berr_n_i` is high and data[1] is low, and 2 (24-bit address, 16-bit data) otherwise. `clk_sel_o` = `modclk_i`, and `bgnd_en_o` = NOT `bkpt_n_i`.
- R9: When enabled, the monitor raises `bus_err_o` for exactly one clock at the BM_TIMEOUT-th edge of a cycle that has had no acknowledge. This pulse is a deferred reset source (cause bit 6).
- R10: With `busmon_en_i` low and no deferred request waiting, a hung cycle never produces `bus_err_o`. A waiting deferred request forces the monitor on.
- R11: Requests that arrive while reset is asserted are ignored. They do not lengthen the reset, do not change `cause_o`, and cause no reset after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all outputs change only on its rising edge |
| rst_i | input | 1 | Power-up reset, synchronous active high |
| pin_rst_req_i | input | 1 | External reset pin request (immediate class) |
| clk_loss_req_i | input | 1 | Clock reference loss request (immediate class) |
| wdog_req_i | input | 1 | Watchdog timeout request (deferred class) |
| halt_req_i | input | 1 | Internal halt request (deferred class) |
| test_req_i | input | 1 | Test reset request (deferred class) |
| bus_cyc_i | input | 1 | High while a bus cycle is in progress |
| bus_ack_i | input | 1 | Normal termination of the current cycle |
| busmon_en_i | input | 1 | Software enable of the bus monitor |
| strap_data_i | input | 16 | Data bus straps sampled during reset |
| berr_n_i | input | 1 | Bus-mode strap, low selects single-chip |
| modclk_i | input | 1 | Clock-source strap |
| bkpt_n_i | input | 1 | Background-debug strap, low enables |
| ext_rst_o | output | 1 | Reset to the external pad |
| clk_rst_o | output | 1 | Reset to the clock module |
| mst_rst_o | output | 1 | Reset to all other internal logic |
| bus_err_o | output | 1 | One-clock bus-error termination from the monitor |
| cause_o | output | 7 | One-hot cause of the most recent reset |
| cfg_module_o | output | 4 | Latched module configuration field |
| cfg_pins_o | output | 11 | Latched pin configuration field |
| bus_mode_o | output | 2 | Decoded external bus mode |
| clk_sel_o | output | 1 | Latched clock-source select |
| bgnd_en_o | output | 1 | Latched background-debug enable |

## Verification
The bench builds the block with HOLD_CYCLES=16 and BM_TIMEOUT=8 instead of 512 and 64. This keeps every reset window and monitor timeout short enough to count edge by edge. It brings the release edge, the strap capture on the last reset clock, and the saturated monitor count of a hung cycle with software enable off into reach in a few dozen clocks. These small values also let one run hold a deferred request across several blocked cycles, check priority ties, and inject requests in the middle of a reset window.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int NUM_SRC     = 7;
    localparam int SRC_POR     = 0;
    localparam int SRC_PIN     = 1;
    localparam int SRC_CLKLOSS = 2;
    localparam int SRC_WDOG    = 3;
    localparam int SRC_HALT    = 4;
    localparam int SRC_TEST    = 5;
    localparam int SRC_BUSMON  = 6;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam src_vec_t IMMEDIATE_MASK = src_vec_t'((1 << SRC_PIN) | (1 << SRC_CLKLOSS));
    localparam src_vec_t DEFERRED_MASK  = src_vec_t'((1 << SRC_WDOG) | (1 << SRC_HALT)
                                                   | (1 << SRC_TEST) | (1 << SRC_BUSMON));

    typedef enum logic [1:0] {
        BUS_SINGLE = 2'd0,
        BUS_PART8  = 2'd1,
        BUS_FULL16 = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic [15:0] data;
        logic        berr_n;
        logic        modclk;
        logic        bkpt_n;
    } strap_t;

    typedef struct packed {
        logic [3:0]  module_cfg;
        logic [10:0] pin_cfg;
        bus_mode_e   mode;
        logic        clk_sel;
        logic        bgnd_en;
    } cfg_t;

    function automatic cfg_t decode_straps(strap_t s);
        cfg_t c;
        c.module_cfg = s.data[15:12];
        c.pin_cfg    = {s.data[11:2], s.data[0]};
        if (!s.berr_n)
            c.mode = BUS_SINGLE;
        else if (!s.data[1])
            c.mode = BUS_PART8;
        else
            c.mode = BUS_FULL16;
        c.clk_sel = s.modclk;
        c.bgnd_en = ~s.bkpt_n;
        return c;
    endfunction

    function automatic src_vec_t pick_first(src_vec_t v);
        src_vec_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rstseq_busmon.sv
module rstseq_busmon #(
    parameter int TIMEOUT = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cyc_i,
    input  logic ack_i,
    input  logic en_i,
    input  logic hold_off_i,
    output logic berr_o
);
    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;
    logic          berr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            berr_q <= 1'b0;
        end else begin
            berr_q <= 1'b0;
            if (!cyc_i || ack_i || hold_off_i || berr_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                if (en_i) begin
                    berr_q <= 1'b1;
                    cnt_q  <= '0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign berr_o = berr_q;

    AST_BERR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        berr_q |=> !berr_q); // R9

    AST_BERR_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        berr_q |-> $past(en_i && cyc_i && !ack_i)); // R10

endmodule

// File: rtl/rstseq_arbiter.sv
module rstseq_arbiter
    import rstseq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     in_rst_i,
    input  src_vec_t req_i,
    input  logic     boundary_i,
    output logic     fire_o,
    output logic     pend_any_o,
    output src_vec_t cause_o
);
    src_vec_t pend_q;
    src_vec_t cause_q;
    src_vec_t deferred;
    src_vec_t cand;

    always_comb begin
        deferred = pend_q | (req_i & DEFERRED_MASK);
        cand     = (req_i & IMMEDIATE_MASK)
                 | (deferred & {NUM_SRC{boundary_i}});
    end

    assign fire_o     = !in_rst_i && (|cand);
    assign pend_any_o = |pend_q;
    assign cause_o    = cause_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q  <= '0;
            cause_q <= src_vec_t'(1 << SRC_POR);
        end else if (in_rst_i || fire_o) begin
            pend_q <= '0;
            if (fire_o)
                cause_q <= pick_first(cand);
        end else begin
            pend_q <= deferred;
        end
    end

    AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(cause_q)); // R6

    AST_NO_PEND_DURING_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        in_rst_i |=> (pend_q == '0)); // R11

endmodule

// File: rtl/rstseq_cfg_latch.sv
module rstseq_cfg_latch
    import rstseq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   cap_i,
    input  strap_t strap_i,
    output cfg_t   cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cfg_q <= decode_straps('1);
        else if (cap_i)
            cfg_q <= decode_straps(strap_i);
    end

    assign cfg_o = cfg_q;

    AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !cap_i |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYCLES = 512,
    parameter int BM_TIMEOUT  = 64
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        pin_rst_req_i,
    input  logic        clk_loss_req_i,
    input  logic        wdog_req_i,
    input  logic        halt_req_i,
    input  logic        test_req_i,
    input  logic        bus_cyc_i,
    input  logic        bus_ack_i,
    input  logic        busmon_en_i,
    input  logic [15:0] strap_data_i,
    input  logic        berr_n_i,
    input  logic        modclk_i,
    input  logic        bkpt_n_i,
    output logic        ext_rst_o,
    output logic        clk_rst_o,
    output logic        mst_rst_o,
    output logic        bus_err_o,
    output logic [6:0]  cause_o,
    output logic [3:0]  cfg_module_o,
    output logic [10:0] cfg_pins_o,
    output logic [1:0]  bus_mode_o,
    output logic        clk_sel_o,
    output logic        bgnd_en_o
);
    localparam int HW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    logic          in_rst_q;
    logic [HW-1:0] hold_cnt_q;
    logic          fire;
    logic          pend_any;
    logic          berr;
    logic          boundary;
    logic          capture;
    src_vec_t      req;
    src_vec_t      cause;
    strap_t        straps;
    cfg_t          cfg;

    always_comb begin
        req              = '0;
        req[SRC_PIN]     = pin_rst_req_i;
        req[SRC_CLKLOSS] = clk_loss_req_i;
        req[SRC_WDOG]    = wdog_req_i;
        req[SRC_HALT]    = halt_req_i;
        req[SRC_TEST]    = test_req_i;
        req[SRC_BUSMON]  = berr;
    end

    assign boundary = !bus_cyc_i || bus_ack_i || berr;
    assign capture  = in_rst_q && (hold_cnt_q == HOLD_LAST);

    always_comb begin
        straps.data   = strap_data_i;
        straps.berr_n = berr_n_i;
        straps.modclk = modclk_i;
        straps.bkpt_n = bkpt_n_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            in_rst_q   <= 1'b1;
            hold_cnt_q <= '0;
        end else if (in_rst_q) begin
            if (hold_cnt_q == HOLD_LAST) begin
                in_rst_q   <= 1'b0;
                hold_cnt_q <= '0;
            end else begin
                hold_cnt_q <= hold_cnt_q + 1'b1;
            end
        end else if (fire) begin
            in_rst_q   <= 1'b1;
            hold_cnt_q <= '0;
        end
    end

    rstseq_busmon #(.TIMEOUT(BM_TIMEOUT)) i_busmon (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cyc_i      (bus_cyc_i),
        .ack_i      (bus_ack_i),
        .en_i       (busmon_en_i || pend_any),
        .hold_off_i (in_rst_q),
        .berr_o     (berr)
    );

    rstseq_arbiter i_arbiter (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .in_rst_i   (in_rst_q),
        .req_i      (req),
        .boundary_i (boundary),
        .fire_o     (fire),
        .pend_any_o (pend_any),
        .cause_o    (cause)
    );

    rstseq_cfg_latch i_cfg_latch (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cap_i   (capture),
        .strap_i (straps),
        .cfg_o   (cfg)
    );

    assign mst_rst_o    = in_rst_q;
    assign ext_rst_o    = in_rst_q;
    assign clk_rst_o    = in_rst_q && !cause[SRC_WDOG];
    assign bus_err_o    = berr;
    assign cause_o      = cause;
    assign cfg_module_o = cfg.module_cfg;
    assign cfg_pins_o   = cfg.pin_cfg;
    assign bus_mode_o   = cfg.mode;
    assign clk_sel_o    = cfg.clk_sel;
    assign bgnd_en_o    = cfg.bgnd_en;

    AST_IMMEDIATE_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!in_rst_q && (pin_rst_req_i || clk_loss_req_i)) |=> in_rst_q); // R2

    AST_DEFERRED_WAITS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!in_rst_q && bus_cyc_i && !bus_ack_i && !berr
         && !pin_rst_req_i && !clk_loss_req_i) |=> !in_rst_q); // R3

    AST_WINDOW_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_rst_q && !capture) |=> (in_rst_q && $stable(cause))); // R11

    AST_RELEASE_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        capture |=> !mst_rst_o && !clk_rst_o); // R4

endmodule

// File: tb/test_reset_sequencer.sv
`timescale 1ns/1ps
module test_reset_sequencer;

    localparam int HOLD = 16;
    localparam int TO   = 8;

    logic        clk = 1'b0;
    logic        rst_i, pin_rst_req_i, clk_loss_req_i, wdog_req_i, halt_req_i, test_req_i;
    logic        bus_cyc_i, bus_ack_i, busmon_en_i;
    logic [15:0] strap_data_i;
    logic        berr_n_i, modclk_i, bkpt_n_i;
    logic        ext_rst_o, clk_rst_o, mst_rst_o, bus_err_o;
    logic [6:0]  cause_o;
    logic [3:0]  cfg_module_o;
    logic [10:0] cfg_pins_o;
    logic [1:0]  bus_mode_o;
    logic        clk_sel_o, bgnd_en_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    reset_sequencer #(.HOLD_CYCLES(HOLD), .BM_TIMEOUT(TO)) i_reset_sequencer (
        .clk_i(clk), .rst_i(rst_i), .pin_rst_req_i(pin_rst_req_i),
        .clk_loss_req_i(clk_loss_req_i), .wdog_req_i(wdog_req_i),
        .halt_req_i(halt_req_i), .test_req_i(test_req_i),
        .bus_cyc_i(bus_cyc_i), .bus_ack_i(bus_ack_i), .busmon_en_i(busmon_en_i),
        .strap_data_i(strap_data_i), .berr_n_i(berr_n_i), .modclk_i(modclk_i),
        .bkpt_n_i(bkpt_n_i), .ext_rst_o(ext_rst_o), .clk_rst_o(clk_rst_o),
        .mst_rst_o(mst_rst_o), .bus_err_o(bus_err_o), .cause_o(cause_o),
        .cfg_module_o(cfg_module_o), .cfg_pins_o(cfg_pins_o), .bus_mode_o(bus_mode_o),
        .clk_sel_o(clk_sel_o), .bgnd_en_o(bgnd_en_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (mst_rst_o === 1'b1 && n < 200) begin
            n++;
            step();
        end
    endtask

    task automatic idle_inputs();
        pin_rst_req_i = 0; clk_loss_req_i = 0; wdog_req_i = 0; halt_req_i = 0;
        test_req_i = 0; bus_cyc_i = 0; bus_ack_i = 0; busmon_en_i = 0;
        strap_data_i = '1; berr_n_i = 1; modclk_i = 1; bkpt_n_i = 1;
    endtask

    task automatic t_powerup();
        int n;
        chk("R1", "mst", mst_rst_o, 1);
        chk("R1", "ext", ext_rst_o, 1);
        chk("R1", "clkrst", clk_rst_o, 1);
        chk("R1", "cause", cause_o, 7'h01);
        chk("R1", "module", cfg_module_o, 4'hF);
        chk("R1", "pins", cfg_pins_o, 11'h7FF);
        chk("R8", "mode default", bus_mode_o, 2);
        chk("R1", "clk_sel", clk_sel_o, 1);
        chk("R1", "bgnd", bgnd_en_o, 0);
        rst_i = 0;
        wait_release(n);
        chk("R4", "por hold", n, HOLD);
        chk("R4", "ext released", ext_rst_o, 0);
        chk("R4", "clkrst released", clk_rst_o, 0);
    endtask

    task automatic t_async_pin();
        int n;
        logic [15:0] d;
        d = 16'hA5C4;
        bus_cyc_i = 1;
        step(); step();
        pin_rst_req_i = 1;
        step();
        pin_rst_req_i = 0;
        chk("R2", "pin mid-cycle mst", mst_rst_o, 1);
        chk("R5", "pin ext", ext_rst_o, 1);
        chk("R5", "pin clkrst", clk_rst_o, 1);
        chk("R6", "pin cause", cause_o, 7'h02);
        bus_cyc_i = 0;
        strap_data_i = d; berr_n_i = 1; modclk_i = 0; bkpt_n_i = 0;
        wait_release(n);
        chk("R4", "pin hold", n, HOLD);
        chk("R8", "module field", cfg_module_o, d[15:12]);
        chk("R8", "pin field", cfg_pins_o, {d[11:2], d[0]});
        chk("R8", "mode part8", bus_mode_o, 1);
        chk("R8", "clk_sel", clk_sel_o, 0);
        chk("R8", "bgnd", bgnd_en_o, 1);
        strap_data_i = 16'h0000; berr_n_i = 0; modclk_i = 1; bkpt_n_i = 1;
        step(); step();
        chk("R7", "module held", cfg_module_o, d[15:12]);
        chk("R7", "pins held", cfg_pins_o, {d[11:2], d[0]});
        chk("R7", "mode held", bus_mode_o, 1);
        idle_inputs();
        step();
    endtask

    task automatic t_sync_wdog();
        int n;
        busmon_en_i = 1;
        bus_cyc_i = 1;
        wdog_req_i = 1;
        step();
        wdog_req_i = 0;
        chk("R3", "wdog deferred e1", mst_rst_o, 0);
        step();
        chk("R3", "wdog deferred e2", mst_rst_o, 0);
        step();
        chk("R3", "wdog deferred e3", mst_rst_o, 0);
        bus_ack_i = 1;
        step();
        bus_ack_i = 0; bus_cyc_i = 0;
        chk("R3", "wdog at boundary", mst_rst_o, 1);
        chk("R5", "wdog ext", ext_rst_o, 1);
        chk("R5", "wdog no clkrst", clk_rst_o, 0);
        chk("R6", "wdog cause", cause_o, 7'h08);
        wait_release(n);
        chk("R4", "wdog hold", n, HOLD);
        busmon_en_i = 0;
    endtask

    task automatic t_halt_idle();
        int n;
        halt_req_i = 1;
        step();
        halt_req_i = 0;
        chk("R3", "halt idle immediate", mst_rst_o, 1);
        chk("R5", "halt clkrst", clk_rst_o, 1);
        chk("R6", "halt cause", cause_o, 7'h10);
        wait_release(n);
        chk("R4", "halt hold", n, HOLD);
    endtask

    task automatic t_priority();
        int n;
        pin_rst_req_i = 1; halt_req_i = 1; test_req_i = 1;
        step();
        pin_rst_req_i = 0; halt_req_i = 0; test_req_i = 0;
        chk("R6", "pin beats halt/test", cause_o, 7'h02);
        wait_release(n);
        wdog_req_i = 1; halt_req_i = 1;
        step();
        wdog_req_i = 0; halt_req_i = 0;
        chk("R6", "wdog beats halt", cause_o, 7'h08);
        chk("R5", "tie wdog no clkrst", clk_rst_o, 0);
        wait_release(n);
        chk("R4", "tie hold", n, HOLD);
    endtask

    task automatic t_busmon();
        int n;
        busmon_en_i = 1;
        bus_cyc_i = 1;
        for (int i = 1; i < TO; i++) begin
            step();
            chk("R9", "no early berr", bus_err_o, 0);
        end
        step();
        chk("R9", "berr at timeout", bus_err_o, 1);
        chk("R9", "no reset yet", mst_rst_o, 0);
        bus_cyc_i = 0;
        step();
        chk("R9", "berr one clock", bus_err_o, 0);
        chk("R9", "busmon reset", mst_rst_o, 1);
        chk("R9", "busmon cause", cause_o, 7'h40);
        wait_release(n);
        busmon_en_i = 0;
    endtask

    task automatic t_forced();
        int n;
        int seen;
        seen = 0;
        busmon_en_i = 0;
        bus_cyc_i = 1;
        for (int i = 0; i < 3 * TO; i++) begin
            step();
            if (bus_err_o !== 1'b0 || mst_rst_o !== 1'b0) seen++;
        end
        chk("R10", "disabled hung cycle quiet", seen, 0);
        test_req_i = 1;
        step();
        test_req_i = 0;
        chk("R10", "pending not yet ended", bus_err_o, 0);
        chk("R3", "test deferred", mst_rst_o, 0);
        step();
        chk("R10", "forced berr", bus_err_o, 1);
        chk("R10", "still no reset", mst_rst_o, 0);
        step();
        bus_cyc_i = 0;
        chk("R10", "reset after forced end", mst_rst_o, 1);
        chk("R6", "test beats busmon", cause_o, 7'h20);
        wait_release(n);
        chk("R4", "test hold", n, HOLD);
    endtask

    task automatic t_ignore();
        int n;
        halt_req_i = 1;
        step();
        halt_req_i = 0;
        n = 0;
        while (mst_rst_o === 1'b1 && n < 200) begin
            n++;
            if (n == 5) begin
                pin_rst_req_i = 1; wdog_req_i = 1;
            end else begin
                pin_rst_req_i = 0; wdog_req_i = 0;
            end
            step();
        end
        pin_rst_req_i = 0; wdog_req_i = 0;
        chk("R11", "hold not extended", n, HOLD);
        chk("R11", "cause unchanged", cause_o, 7'h10);
        step(); step(); step();
        chk("R11", "no reset after release", mst_rst_o, 0);
    endtask

    task automatic t_clkloss();
        int n;
        berr_n_i = 0;
        clk_loss_req_i = 1;
        step();
        clk_loss_req_i = 0;
        chk("R2", "clk loss immediate", mst_rst_o, 1);
        chk("R5", "clk loss clkrst", clk_rst_o, 1);
        chk("R6", "clk loss cause", cause_o, 7'h04);
        wait_release(n);
        chk("R8", "single chip mode", bus_mode_o, 0);
        chk("R8", "module all high", cfg_module_o, 4'hF);
        berr_n_i = 1;
    endtask

    initial begin
        idle_inputs();
        rst_i = 1;
        repeat (3) step();
        t_powerup();
        t_async_pin();
        t_sync_wdog();
        t_halt_idle();
        t_priority();
        t_busmon();
        t_forced();
        t_ignore();
        t_clkloss();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule